// File: doc/BRIEF.md
# Dual-Context State File Swapper

This block keeps two physical copies of a thread context so that a processor can change threads on a long-latency miss without waiting for context storage traffic. Each context is a flat array of register words; word 0 is the program counter and word 1 is the status word. One copy is active and serves the pipeline's register read/write port. The other copy is idle. In the background it writes its previous thread back to a backing state store and then fills itself with the next ready thread.

Ready thread IDs are pushed into a small internal queue. The backing store is an internal RAM addressed by thread ID, with each thread taking a block of whole transfer beats. When a miss is reported and the idle copy is already filled, the two copies trade roles at the next clock edge. When the idle copy is still busy, the block raises a stall until the swap can occur. When the idle copy empties and no thread is queued, the block reports that no thread is ready and leaves the idle copy empty until an ID arrives.

Top module: `ctx_swapper`

## Requirements
- R1: While reset is held, run_valid_o, stall_o and no_ready_o are 0. One clock after reset is released with an empty queue, no_ready_o is 1.
- R2: A pushed thread ID is loaded into the idle copy from the store, one 128-bit beat per cycle over 32 beats. If no thread is running at that point, the idle copy becomes active on its own: run_valid_o goes to 1 and cur_tid_o shows the ID.
- R3: A write on the register port updates word rf_waddr_i of the active copy. rf_rdata_o returns word rf_raddr_i of the active copy one clock after the address is presented. pc_o shows word 0 and status_o shows word 1.
- R4: A miss while a thread runs and the idle copy is filled changes cur_tid_o at the next clock edge. stall_o stays 0.
- R5: The copy displaced by a swap is written to the store at beat address thread_id*32 + beat. A later reload of that thread ID restores every word exactly, including the program counter and status words.
- R6: A miss that arrives while the idle copy is still saving or loading raises stall_o from the next edge until the swap. If the miss comes one cycle after a swap and a thread is queued, stall_o stays high for exactly 2*32+2 cycles, after which the queued thread is active.
- R7: If the idle copy empties while the queue is empty, no_ready_o rises, the idle copy stays empty, and a pending miss keeps stall_o high. A later push starts the load, clears no_ready_o, and the swap follows.
- R8: A miss while no thread is running is ignored: stall_o stays 0.
- R9: Queued thread IDs are loaded in the order they were pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_i | input | 1 | Long-latency miss of the running thread |
| rq_push_i | input | 1 | Push a ready thread ID into the queue |
| rq_tid_i | input | 3 | Thread ID to push |
| rf_we_i | input | 1 | Register write enable (active copy) |
| rf_waddr_i | input | 7 | Register write word index |
| rf_wdata_i | input | 32 | Register write data |
| rf_raddr_i | input | 7 | Register read word index |
| rf_rdata_o | output | 32 | Registered read data |
| pc_o | output | 32 | Word 0 of the active copy |
| status_o | output | 32 | Word 1 of the active copy |
| run_valid_o | output | 1 | A thread occupies the active copy |
| cur_tid_o | output | 3 | ID of the running thread |
| stall_o | output | 1 | Miss pending, waiting for the idle copy |
| no_ready_o | output | 1 | Idle copy empty and no thread queued |

## Verification
The bench writes distinct patterns into two threads, including both state words and words on either side of a beat boundary. After each thread has gone through the store, it reads every pattern back. A design with a wrong beat-to-word mapping or a wrong thread offset in the store would return the other thread's data or shifted words. The stall window after a back-to-back miss is counted cycle by cycle, so an extra or missing pipeline stage in the save or load path shows up as a wrong count. The bench also holds a miss against an empty queue and pushes IDs in a known order. A design that retired the stall too early, or that popped IDs in the wrong order, would show the wrong thread running.

// File: rtl/ctxsw_pkg.sv
package ctxsw_pkg;
  typedef enum logic [1:0] {
    BG_EMPTY,
    BG_SAVE,
    BG_LOAD,
    BG_READY
  } bg_state_e;
endpackage

// File: rtl/ready_fifo.sv
module ready_fifo #(
  parameter int DEPTH = 4,
  parameter int ID_W  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic [ID_W-1:0] push_id,
  input  logic            pop,
  output logic            empty,
  output logic [ID_W-1:0] head_id
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ID_W-1:0]  slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             full, do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head_id = slot_q[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) slot_q[wr_ptr] <= push_id;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  AST_FIFO_GROW: assert property (@(posedge clk) disable iff (rst)
    (push && !full && !pop) |=> (count == $past(count) + CNT_W'(1))); // R9
  AST_FIFO_DRAIN: assert property (@(posedge clk) disable iff (rst)
    (pop && !empty && !push) |=> (count == $past(count) - CNT_W'(1))); // R9
endmodule

// File: rtl/state_store.sv
module state_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ctx_bank.sv
module ctx_bank #(
  parameter int REG_W  = 32,
  parameter int NWORDS = 128,
  parameter int XFER_W = 128
) (
  input  logic                          clk,
  input  logic                          act_sel,
  input  logic                          rf_we,
  input  logic [$clog2(NWORDS)-1:0]     rf_waddr,
  input  logic [REG_W-1:0]              rf_wdata,
  input  logic [$clog2(NWORDS)-1:0]     rf_raddr,
  output logic [REG_W-1:0]              rf_rdata,
  input  logic                          ld_we,
  input  logic [$clog2(NWORDS*REG_W/XFER_W)-1:0] ld_beat,
  input  logic [XFER_W-1:0]             ld_data,
  input  logic [$clog2(NWORDS*REG_W/XFER_W)-1:0] sv_beat,
  output logic [XFER_W-1:0]             sv_data,
  output logic [REG_W-1:0]              pc,
  output logic [REG_W-1:0]              status
);
  localparam int WPB  = XFER_W / REG_W;
  localparam int WI_W = $clog2(WPB);

  logic [REG_W-1:0] copy_q [2][NWORDS];
  logic             idle_sel;

  assign idle_sel = ~act_sel;

  always_ff @(posedge clk) begin
    if (rf_we) copy_q[act_sel][rf_waddr] <= rf_wdata;
    if (ld_we) begin
      for (int k = 0; k < WPB; k++) begin
        copy_q[idle_sel][{ld_beat, WI_W'(k)}] <= ld_data[k*REG_W +: REG_W];
      end
    end
    rf_rdata <= copy_q[act_sel][rf_raddr];
  end

  for (genvar g = 0; g < WPB; g++) begin : g_save_lane
    assign sv_data[g*REG_W +: REG_W] = copy_q[idle_sel][{sv_beat, WI_W'(g)}];
  end

  assign pc     = copy_q[act_sel][0];
  assign status = copy_q[act_sel][1];
endmodule

// File: rtl/ctx_swapper.sv
module ctx_swapper #(
  parameter int REG_W   = 32,
  parameter int NWORDS  = 128,
  parameter int XFER_W  = 128,
  parameter int THREADS = 8,
  parameter int QDEPTH  = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        miss_i,
  input  logic                        rq_push_i,
  input  logic [$clog2(THREADS)-1:0]  rq_tid_i,
  input  logic                        rf_we_i,
  input  logic [$clog2(NWORDS)-1:0]   rf_waddr_i,
  input  logic [REG_W-1:0]            rf_wdata_i,
  input  logic [$clog2(NWORDS)-1:0]   rf_raddr_i,
  output logic [REG_W-1:0]            rf_rdata_o,
  output logic [REG_W-1:0]            pc_o,
  output logic [REG_W-1:0]            status_o,
  output logic                        run_valid_o,
  output logic [$clog2(THREADS)-1:0]  cur_tid_o,
  output logic                        stall_o,
  output logic                        no_ready_o
);
  import ctxsw_pkg::*;

  localparam int BEATS = NWORDS * REG_W / XFER_W;
  localparam int BI_W  = $clog2(BEATS);
  localparam int ID_W  = $clog2(THREADS);
  localparam int SA_W  = ID_W + BI_W;
  localparam logic [BI_W-1:0] LAST_BEAT = BI_W'(BEATS - 1);

  bg_state_e         bg_st;
  logic              act_sel, act_valid, miss_pend, no_ready_q;
  logic [ID_W-1:0]   act_tid, bg_tid;
  logic [BI_W-1:0]   xcnt, ld_widx;
  logic              ld_iss, ld_wv;
  logic              want_sw, do_sw, fifo_pop, fifo_empty;
  logic [ID_W-1:0]   fifo_head;
  logic [XFER_W-1:0] sv_data, st_rdata;
  logic [SA_W-1:0]   st_addr;

  assign want_sw  = (miss_i && act_valid) || miss_pend || !act_valid;
  assign do_sw    = want_sw && (bg_st == BG_READY);
  assign fifo_pop = (bg_st == BG_EMPTY) && !fifo_empty;
  assign st_addr  = {bg_tid, xcnt};

  ready_fifo #(.DEPTH(QDEPTH), .ID_W(ID_W)) u_rq (
    .clk(clk), .rst(rst), .push(rq_push_i), .push_id(rq_tid_i),
    .pop(fifo_pop), .empty(fifo_empty), .head_id(fifo_head)
  );

  state_store #(.ADDR_W(SA_W), .DATA_W(XFER_W)) u_store (
    .clk(clk), .we(bg_st == BG_SAVE), .waddr(st_addr), .wdata(sv_data),
    .raddr(st_addr), .rdata(st_rdata)
  );

  ctx_bank #(.REG_W(REG_W), .NWORDS(NWORDS), .XFER_W(XFER_W)) u_bank (
    .clk(clk), .act_sel(act_sel),
    .rf_we(rf_we_i && act_valid), .rf_waddr(rf_waddr_i), .rf_wdata(rf_wdata_i),
    .rf_raddr(rf_raddr_i), .rf_rdata(rf_rdata_o),
    .ld_we(ld_wv), .ld_beat(ld_widx), .ld_data(st_rdata),
    .sv_beat(xcnt), .sv_data(sv_data),
    .pc(pc_o), .status(status_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bg_st      <= BG_EMPTY;
      act_sel    <= 1'b0;
      act_valid  <= 1'b0;
      act_tid    <= '0;
      bg_tid     <= '0;
      xcnt       <= '0;
      ld_iss     <= 1'b0;
      ld_wv      <= 1'b0;
      ld_widx    <= '0;
      miss_pend  <= 1'b0;
      no_ready_q <= 1'b0;
    end else begin
      ld_wv      <= 1'b0;
      no_ready_q <= (bg_st == BG_EMPTY) && fifo_empty;
      if (do_sw) miss_pend <= 1'b0;
      else if (miss_i && act_valid) miss_pend <= 1'b1;

      unique case (bg_st)
        BG_READY: begin
          if (do_sw) begin
            act_sel   <= ~act_sel;
            act_valid <= 1'b1;
            act_tid   <= bg_tid;
            bg_tid    <= act_tid;
            xcnt      <= '0;
            bg_st     <= act_valid ? BG_SAVE : BG_EMPTY;
          end
        end
        BG_SAVE: begin
          xcnt <= xcnt + BI_W'(1);
          if (xcnt == LAST_BEAT) bg_st <= BG_EMPTY;
        end
        BG_EMPTY: begin
          if (fifo_pop) begin
            bg_tid <= fifo_head;
            xcnt   <= '0;
            ld_iss <= 1'b1;
            bg_st  <= BG_LOAD;
          end
        end
        BG_LOAD: begin
          if (ld_iss) begin
            ld_wv   <= 1'b1;
            ld_widx <= xcnt;
            xcnt    <= xcnt + BI_W'(1);
            if (xcnt == LAST_BEAT) ld_iss <= 1'b0;
          end
          if (ld_wv && ld_widx == LAST_BEAT) bg_st <= BG_READY;
        end
        default: bg_st <= BG_EMPTY;
      endcase
    end
  end

  assign run_valid_o = act_valid;
  assign cur_tid_o   = act_tid;
  assign stall_o     = miss_pend;
  assign no_ready_o  = no_ready_q;

  AST_LOAD_DONE: assert property (@(posedge clk) disable iff (rst)
    (ld_wv && ld_widx == LAST_BEAT) |=> (bg_st == BG_READY)); // R2
  AST_SWAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (bg_st == BG_READY && (miss_pend || !act_valid)) |=> (act_sel != $past(act_sel))); // R4
  AST_SAVE_LEN: assert property (@(posedge clk) disable iff (rst)
    (bg_st == BG_SAVE && xcnt == LAST_BEAT) |=> (bg_st == BG_EMPTY)); // R5
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (miss_pend && bg_st != BG_READY) |=> miss_pend); // R6
  AST_NO_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
    no_ready_q |-> (bg_st == BG_EMPTY)); // R7
  AST_MISS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!act_valid && !miss_pend) |=> !miss_pend); // R8
endmodule

// File: tb/tb_ctx_swapper.sv
module tb_ctx_swapper;
  localparam int CLK_PERIOD = 10;
  localparam int BEATS = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        miss_i = 1'b0;
  logic        rq_push_i = 1'b0;
  logic [2:0]  rq_tid_i = '0;
  logic        rf_we_i = 1'b0;
  logic [6:0]  rf_waddr_i = '0;
  logic [31:0] rf_wdata_i = '0;
  logic [6:0]  rf_raddr_i = '0;
  logic [31:0] rf_rdata_o, pc_o, status_o;
  logic        run_valid_o, stall_o, no_ready_o;
  logic [2:0]  cur_tid_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // word index (7 bits) and data pattern (32 bits)
  localparam logic [38:0] VEC [8] = '{
    {7'd0,   32'h0000_1000}, {7'd1,   32'h8000_0001},
    {7'd2,   32'hA5A5_0002}, {7'd3,   32'h1234_5678},
    {7'd4,   32'hDEAD_BEEF}, {7'd63,  32'h0F0F_F0F0},
    {7'd64,  32'hCAFE_0040}, {7'd127, 32'h7777_007F}
  };
  localparam logic [31:0] T5_XOR = 32'h5A5A_0000;

  ctx_swapper dut (
    .clk(clk), .rst(rst), .miss_i(miss_i), .rq_push_i(rq_push_i), .rq_tid_i(rq_tid_i),
    .rf_we_i(rf_we_i), .rf_waddr_i(rf_waddr_i), .rf_wdata_i(rf_wdata_i),
    .rf_raddr_i(rf_raddr_i), .rf_rdata_o(rf_rdata_o), .pc_o(pc_o), .status_o(status_o),
    .run_valid_o(run_valid_o), .cur_tid_o(cur_tid_o), .stall_o(stall_o), .no_ready_o(no_ready_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] tid);
    rq_push_i = 1'b1;
    rq_tid_i  = tid;
    tick();
    rq_push_i = 1'b0;
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    rf_we_i = 1'b1;
    rf_waddr_i = a;
    rf_wdata_i = d;
    tick();
    rf_we_i = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    rf_raddr_i = a;
    tick();
    d = rf_rdata_o;
  endtask

  task automatic check_thread(input string req, input logic [31:0] xr);
    logic [31:0] d;
    for (int i = 0; i < 8; i++) begin
      rd(VEC[i][38:32], d);
      chk(req, d, VEC[i][31:0] ^ xr);
    end
    chk(req, pc_o, VEC[0][31:0] ^ xr);
    chk(req, status_o, VEC[1][31:0] ^ xr);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    @(negedge clk);
    tick(); tick();
    // R1 reset state
    chk("R1 run_valid", 32'(run_valid_o), 0);
    chk("R1 stall", 32'(stall_o), 0);
    chk("R1 no_ready", 32'(no_ready_o), 0);
    rst = 1'b0;
    tick();
    chk("R1 no_ready after reset", 32'(no_ready_o), 1);

    // R8 miss with nothing running
    miss_i = 1'b1; tick(); miss_i = 1'b0;
    tick();
    chk("R8 stall", 32'(stall_o), 0);
    chk("R8 run_valid", 32'(run_valid_o), 0);

    // R2 / R9 first load and auto activation
    push(3'd2);
    push(3'd5);
    n = 0;
    while (!run_valid_o && n < 200) begin tick(); n++; end
    chk("R2 run_valid", 32'(run_valid_o), 1);
    chk("R9 first tid", 32'(cur_tid_o), 2);
    repeat (40) tick();

    // R3 table of writes, then read back
    for (int i = 0; i < 8; i++) wr(VEC[i][38:32], VEC[i][31:0]);
    check_thread("R3", 32'h0);

    // R4 single-cycle swap to thread 5
    miss_i = 1'b1; tick(); miss_i = 1'b0;
    chk("R4 cur_tid", 32'(cur_tid_o), 5);
    chk("R9 second tid", 32'(cur_tid_o), 5);
    chk("R4 stall", 32'(stall_o), 0);
    for (int i = 0; i < 8; i++) wr(VEC[i][38:32], VEC[i][31:0] ^ T5_XOR);
    push(3'd2);
    repeat (80) tick();

    // R5 thread 2 restored; R6 back-to-back miss
    push(3'd5);
    miss_i = 1'b1; tick();
    chk("R4 cur_tid back", 32'(cur_tid_o), 2);
    chk("R4 stall back", 32'(stall_o), 0);
    tick(); miss_i = 1'b0;
    n = 0;
    while (stall_o && n < 300) begin n++; tick(); end
    chk("R6 stall cycles", 32'(n), 2*BEATS+2);
    chk("R6 cur_tid", 32'(cur_tid_o), 5);
    check_thread("R5 thread5", T5_XOR);

    // R7 queue empty at reload
    repeat (40) tick();
    chk("R7 no_ready", 32'(no_ready_o), 1);
    miss_i = 1'b1; tick(); miss_i = 1'b0;
    repeat (20) tick();
    chk("R7 stall held", 32'(stall_o), 1);
    chk("R7 tid held", 32'(cur_tid_o), 5);
    push(3'd2);
    tick();
    chk("R7 no_ready cleared", 32'(no_ready_o), 0);
    n = 0;
    while (stall_o && n < 200) begin n++; tick(); end
    chk("R7 stall released", 32'(stall_o), 0);
    chk("R7 cur_tid", 32'(cur_tid_o), 2);
    check_thread("R5 thread2", 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule